// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block collects level-sensitive interrupt pin events from PCI devices and drives 32 interrupt output lines. Each event carries a device/function number, a pin index (0 to 3), the requested level, and a flag that says whether the device is on the primary bus or behind a secondary bridge. The router turns these into an output line number and checks the enable of the group that owns that line. It then stores the resulting level in a per-line register.

Output lines are gathered into groups of four that share one enable bit. The enable vector comes from a configuration register file elsewhere in the chip. A disabled group does more than mask new events. Its lines are driven low on the next clock, and any event aimed at them is recorded as low. Priority encoding and acknowledgment belong to the interrupt controller downstream.

Top module: `irq_line_router`

## Requirements
- R1: While reset is asserted, and on the first clock after it, every bit of `irqOut` is 0.
- R2: A primary-bus event (`evtBehindBridge`=0) targets line `pin + 16` when `evtDevfn[0]` is 1, and line `pin` when `evtDevfn[0]` is 0.
- R3: A secondary-bus event (`evtBehindBridge`=1) targets line `4*evtDevfn[4:3] + pin`. The other devfn bits have no effect.
- R4: Line L belongs to group L>>2, whose enable is `groupEnable[L>>2]`. When that bit is 1, an accepted event sets line L to `evtLevel` on the clock edge that samples `evtValid`. This holds for both raising and lowering the line.
- R5: An event that targets a line in a disabled group leaves that line at 0, whatever level was requested.
- R6: When `groupEnable[g]` is 0 at a clock edge, lines 4g to 4g+3 are all 0 after that edge, with or without an event.
- R7: An event whose computed line is NUM_LINES or more changes no output.
- R8: In a clock where `evtValid` is 0 and every group is enabled, all outputs hold their values.
- R9: An accepted event changes only its target line. All other enabled lines hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtValid | input | 1 | Interrupt pin event strobe |
| evtBehindBridge | input | 1 | 1: device is behind a secondary bridge; 0: device is on the primary bus |
| evtDevfn | input | 8 | Device/function number of the source |
| evtPin | input | 2 | Interrupt pin index 0..3 |
| evtLevel | input | 1 | Requested level of the pin |
| groupEnable | input | NUM_LINES/4 | One enable per group of four lines |
| irqOut | output | NUM_LINES | Registered interrupt line levels |

## Verification
The checker watches three rules on every cycle. Lines of disabled groups must be low one clock later. No line may move when there is no event. At most one line may change per event. It also checks that primary-bus and secondary-bus events land on the line their mapping names.

Some behaviours need a sequence that only the bench's scenarios build. One is a group being re-enabled after it forced its lines low. Another is an event dropped for being out of range, which shows only on a second instance built with 16 lines. A third is a long random run in which enables and events interleave, checked against a bench model.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  // Width of a computed line index; wide enough for any offset plus pin.
  localparam int LINE_IDX_W = 8;
  localparam int DEVFN_W    = 8;
  localparam int PIN_W      = 2;

  // Strobes passed from the control decode to the state datapath.
  typedef struct packed {
    logic                  wrStrobe;
    logic                  wrLevel;
    logic [LINE_IDX_W-1:0] lineIdx;
  } route_cmd_t;

endpackage

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_router_pkg::*;
#(
  parameter int NUM_LINES        = 32,
  parameter int PRIMARY_ODD_BASE = 16,
  parameter int LINES_PER_SLOT   = 4
) (
  input  logic             evtValid,
  input  logic             evtBehindBridge,
  input  logic [1:0]       slotSel,
  input  logic             funcOdd,
  input  logic [PIN_W-1:0] evtPin,
  input  logic             evtLevel,
  output route_cmd_t       cmd
);

  localparam logic [LINE_IDX_W-1:0] OddBase  = LINE_IDX_W'(PRIMARY_ODD_BASE);
  localparam logic [LINE_IDX_W-1:0] SlotSpan = LINE_IDX_W'(LINES_PER_SLOT);
  localparam logic [LINE_IDX_W-1:0] LineCnt  = LINE_IDX_W'(NUM_LINES);

  logic [LINE_IDX_W-1:0] pinExt;
  logic [LINE_IDX_W-1:0] primaryLine;
  logic [LINE_IDX_W-1:0] secondaryLine;
  logic [LINE_IDX_W-1:0] rawLine;
  logic                  inRange;

  always_comb begin
    pinExt        = LINE_IDX_W'(evtPin);
    primaryLine   = pinExt + (funcOdd ? OddBase : '0);
    secondaryLine = pinExt + (LINE_IDX_W'(slotSel) * SlotSpan);
    rawLine       = evtBehindBridge ? secondaryLine : primaryLine;
    inRange       = rawLine < LineCnt;
  end

  always_comb begin
    cmd.wrStrobe = evtValid && inRange;
    cmd.wrLevel  = evtLevel;
    cmd.lineIdx  = rawLine;
  end

endmodule

// File: rtl/irq_route_datapath.sv
module irq_route_datapath
  import irq_router_pkg::*;
#(
  parameter int NUM_LINES       = 32,
  parameter int LINES_PER_GROUP = 4,
  localparam int NumGroups      = NUM_LINES / LINES_PER_GROUP
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  route_cmd_t           cmd,
  input  logic [NumGroups-1:0] groupEnable,
  output logic [NUM_LINES-1:0] irqOut
);

  logic [NUM_LINES-1:0] lineState;
  logic [NUM_LINES-1:0] lineNext;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam int GroupIdx = i / LINES_PER_GROUP;
    logic hit;
    assign hit = cmd.wrStrobe && (cmd.lineIdx == LINE_IDX_W'(i));

    always_comb begin
      if (!groupEnable[GroupIdx]) begin
        lineNext[i] = 1'b0;
      end else if (hit) begin
        lineNext[i] = cmd.wrLevel;
      end else begin
        lineNext[i] = lineState[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineState <= '0;
    end else begin
      lineState <= lineNext;
    end
  end

  assign irqOut = lineState;

endmodule

// File: rtl/irq_line_router.sv
module irq_line_router
  import irq_router_pkg::*;
#(
  parameter int NUM_LINES        = 32,
  parameter int LINES_PER_GROUP  = 4,
  parameter int PRIMARY_ODD_BASE = 16,
  localparam int NumGroups       = NUM_LINES / LINES_PER_GROUP
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 evtValid,
  input  logic                 evtBehindBridge,
  input  logic [DEVFN_W-1:0]   evtDevfn,
  input  logic [PIN_W-1:0]     evtPin,
  input  logic                 evtLevel,
  input  logic [NumGroups-1:0] groupEnable,
  output logic [NUM_LINES-1:0] irqOut
);

  route_cmd_t cmd;
  logic       unusedDevfnBits;

  assign unusedDevfnBits = ^{evtDevfn[7:5], evtDevfn[2:1]};

  irq_route_ctrl #(
    .NUM_LINES       (NUM_LINES),
    .PRIMARY_ODD_BASE(PRIMARY_ODD_BASE),
    .LINES_PER_SLOT  (LINES_PER_GROUP)
  ) u_ctrl (
    .evtValid       (evtValid),
    .evtBehindBridge(evtBehindBridge),
    .slotSel        (evtDevfn[4:3]),
    .funcOdd        (evtDevfn[0]),
    .evtPin         (evtPin),
    .evtLevel       (evtLevel),
    .cmd            (cmd)
  );

  irq_route_datapath #(
    .NUM_LINES      (NUM_LINES),
    .LINES_PER_GROUP(LINES_PER_GROUP)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .groupEnable(groupEnable),
    .irqOut     (irqOut)
  );

endmodule

// File: rtl/irq_line_router_chk.sv
module irq_line_router_chk #(
  parameter int NUM_LINES        = 32,
  parameter int LINES_PER_GROUP  = 4,
  parameter int PRIMARY_ODD_BASE = 16,
  localparam int NumGroups       = NUM_LINES / LINES_PER_GROUP
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 evtValid,
  input logic                 evtBehindBridge,
  input logic [7:0]           evtDevfn,
  input logic [1:0]           evtPin,
  input logic                 evtLevel,
  input logic [NumGroups-1:0] groupEnable,
  input logic [NUM_LINES-1:0] irqOut
);

  logic [NUM_LINES-1:0] enMask;
  int unsigned          primLine;
  int unsigned          secLine;
  logic                 primOk;
  logic                 secOk;

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) enMask[i] = groupEnable[i / LINES_PER_GROUP];
    primLine = 32'(evtPin) + (evtDevfn[0] ? 32'(PRIMARY_ODD_BASE) : 32'd0);
    secLine  = 32'(evtPin) + 32'(evtDevfn[4:3]) * 4;
    primOk   = evtValid && !evtBehindBridge && (&groupEnable) && (primLine < NUM_LINES);
    secOk    = evtValid && evtBehindBridge && (&groupEnable) && (secLine < NUM_LINES);
  end

  // R1: reset clears the outputs
  p_reset_clear_r1: assert property (@(posedge clk) !rstN |=> irqOut == '0);

  // R2: primary-bus mapping lands on the expected line
  p_primary_map_r2: assert property (@(posedge clk) disable iff (!rstN)
    primOk |=> irqOut[$past(primLine)] == $past(evtLevel));

  // R3: secondary-bus mapping lands on the expected line
  p_secondary_map_r3: assert property (@(posedge clk) disable iff (!rstN)
    secOk |=> irqOut[$past(secLine)] == $past(evtLevel));

  // R6: disabled groups are low one clock later
  p_disabled_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut & ~$past(enMask)) == '0);

  // R8: no event and all groups enabled means outputs hold
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!evtValid && (&groupEnable)) |=> $stable(irqOut));

  // R9: with all groups enabled, at most one line moves per cycle
  p_single_change_r9: assert property (@(posedge clk) disable iff (!rstN)
    (&groupEnable) |=> $countones(irqOut ^ $past(irqOut)) <= 1);

endmodule

bind irq_line_router irq_line_router_chk #(
  .NUM_LINES       (NUM_LINES),
  .LINES_PER_GROUP (LINES_PER_GROUP),
  .PRIMARY_ODD_BASE(PRIMARY_ODD_BASE)
) u_chk (.*);

// File: tb/test_irq_line_router.sv
module test_irq_line_router;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evtValid = 1'b0;
  logic        evtBehindBridge = 1'b0;
  logic [7:0]  evtDevfn = '0;
  logic [1:0]  evtPin = '0;
  logic        evtLevel = 1'b0;
  logic [7:0]  groupEnable = '0;
  logic [3:0]  narrowEnable = '0;
  logic [31:0] irqOut;
  logic [15:0] irqNarrow;

  logic [31:0] expWide = '0;
  logic [31:0] expNarrow = '0;
  int          errors = 0;
  int          checks = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  irq_line_router i_irq_line_router (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtBehindBridge(evtBehindBridge),
    .evtDevfn(evtDevfn), .evtPin(evtPin), .evtLevel(evtLevel),
    .groupEnable(groupEnable), .irqOut(irqOut)
  );

  // Narrow variant: 16 lines, so odd-function primary devices fall out of range.
  irq_line_router #(.NUM_LINES(16)) i_irq_line_router_narrow (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtBehindBridge(evtBehindBridge),
    .evtDevfn(evtDevfn), .evtPin(evtPin), .evtLevel(evtLevel),
    .groupEnable(narrowEnable), .irqOut(irqNarrow)
  );

  function automatic int lineOf(bit behind, logic [7:0] devfn, logic [1:0] pin);
    if (behind) return 4 * int'(devfn[4:3]) + int'(pin);
    return int'(pin) + (devfn[0] ? 16 : 0);
  endfunction

  function automatic logic [31:0] nextState(logic [31:0] cur, int nLines, bit valid,
      bit behind, logic [7:0] devfn, logic [1:0] pin, bit level, logic [7:0] en);
    logic [31:0] s = cur;
    int ln;
    for (int i = 0; i < nLines; i++) if (!en[i / 4]) s[i] = 1'b0;
    if (valid) begin
      ln = lineOf(behind, devfn, pin);
      if (ln < nLines) s[ln] = en[ln / 4] ? level : 1'b0;
    end
    return s;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit v, input bit b, input logic [7:0] d, input logic [1:0] p,
                      input bit l, input logic [7:0] en, input string tag);
    evtValid = v; evtBehindBridge = b; evtDevfn = d; evtPin = p; evtLevel = l;
    groupEnable = en; narrowEnable = en[3:0];
    @(posedge clk);
    @(negedge clk);
    expWide   = nextState(expWide, 32, v, b, d, p, l, en);
    expNarrow = nextState(expNarrow, 16, v, b, d, p, l, en);
    check(tag, irqOut, expWide);
    check({tag, " narrow"}, {16'b0, irqNarrow}, expNarrow);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    check("R1 reset wide", irqOut, 32'h0);
    check("R1 reset narrow", {16'b0, irqNarrow}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", irqOut, 32'h0);

    // R2: primary mapping
    step(1, 0, 8'h00, 2'd2, 1, 8'hFF, "R2 even func pin2");
    check("R2 line2 set", 32'(irqOut[2]), 32'd1);
    step(1, 0, 8'h01, 2'd3, 1, 8'hFF, "R2 odd func pin3");
    check("R2 line19 set", 32'(irqOut[19]), 32'd1);
    // R7: narrow instance ignores line 19
    check("R7 narrow ignores line19", {16'b0, irqNarrow}, 32'h0004);

    // R3: secondary mapping, upper devfn bits irrelevant
    step(1, 1, 8'hF8, 2'd1, 1, 8'hFF, "R3 slot3 pin1");
    check("R3 line13 set", 32'(irqOut[13]), 32'd1);
    step(1, 1, 8'h0E, 2'd0, 1, 8'hFF, "R3 slot1 pin0");
    check("R3 line4 set", 32'(irqOut[4]), 32'd1);

    // R4: lower a line
    step(1, 1, 8'h18, 2'd1, 0, 8'hFF, "R4 lower line13");
    check("R4 line13 low", 32'(irqOut[13]), 32'd0);

    // R8: idle holds
    step(0, 1, 8'hFF, 2'd3, 1, 8'hFF, "R8 idle hold");

    // R6: group 4 disabled forces line 19 low
    step(0, 0, 8'h00, 2'd0, 0, 8'hEF, "R6 group4 off");
    check("R6 line19 forced", 32'(irqOut[19]), 32'd0);
    // R5: event into disabled group stays low
    step(1, 0, 8'h01, 2'd1, 1, 8'hEF, "R5 event to disabled");
    check("R5 line17 low", 32'(irqOut[17]), 32'd0);
    step(0, 0, 8'h00, 2'd0, 0, 8'hFF, "R6 re-enable keeps low");
    check("R6 line19 still low", 32'(irqOut[19]), 32'd0);
    // R6 on narrow: group 0 off clears line 2
    step(0, 0, 8'h00, 2'd0, 0, 8'hFE, "R6 group0 off");
    check("R6 line2 forced", 32'(irqOut[2]), 32'd0);

    // R9: random mix
    for (int n = 0; n < 400; n++) begin
      logic [7:0] en;
      en = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'hFF;
      step(($urandom_range(0, 3) != 0), 1'($urandom), 8'($urandom), 2'($urandom),
           1'($urandom), en, "R9 random");
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule